// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the control core of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) whose instruction fetch and data accesses share one memory port. Every cycle it looks at the register specifiers, write enables, load flag and redirect outcome of the instructions in flight. From these it decides three things: who gets the memory port, whether the front of the pipe must hold or take a bubble, and where each execute-stage operand comes from.

The controller is purely combinational. The pipeline registers apply its outputs at the next clock edge. A hold keeps a register's contents. A kill loads a bubble with every write enable cleared. Once a bubble is in a pipeline register, the datapath carries it forward stage by stage, and every younger instruction arrives one cycle later. The block has no streaming data interface, so all pins are plain control levels with no valid/ready handshake.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: If a memory access is in the memory stage (`mem_access`=1), a fetch is requested (`fetch_req`=1) and there is no redirect, then the port goes to data (`grant_data`=1, `grant_fetch`=0). In that case `hold_pc`=1 and `kill_ifid`=1, while `hold_ifid`=0 and `kill_idex`=0, provided there is no load-use stall.
- R2: With no redirect, no port conflict and no load-use stall, all hold and kill outputs are 0. `grant_fetch` equals `fetch_req && !mem_access`, and `grant_data` equals `mem_access`.
- R3: An operand select reads 2 (taken from the EX/MEM output) when `mem_wen`=1, `mem_rd` equals that operand's source register, and the source register is nonzero.
- R4: An operand select reads 1 (taken from the MEM/WB output) when `wb_wen`=1, `wb_rd` matches, the register is nonzero and there is no EX/MEM match. Otherwise it reads 0 (register file).
- R5: When EX/MEM and MEM/WB both match the same source register, the select reads 2.
- R6: Register 0 never selects a bypass and never causes a load-use stall.
- R7: A load in execute (`ex_load`=1, `ex_wen`=1, `ex_rd`≠0) whose `ex_rd` equals `id_rs1` or `id_rs2` gives `hold_pc`=1, `hold_ifid`=1 and `kill_idex`=1, with `kill_ifid`=0. This lasts exactly the one cycle in which that pair of stages is occupied.
- R8: When a port conflict and a load-use stall happen together, the result is the same as R7: PC and IF/ID are held, and one bubble goes into ID/EX only.
- R9: A redirect (`ex_redirect`=1) sets `kill_ifid`=1 and `kill_idex`=1, and clears `hold_pc` and `hold_ifid`, whatever the other inputs are.
- R10: `grant_data` and `grant_fetch` are never both 1, and `grant_data` follows `mem_access` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_req | input | 1 | Fetch stage wants the memory port |
| id_rs1 | input | AW | Decode-stage source register 1 |
| id_rs2 | input | AW | Decode-stage source register 2 |
| ex_rs1 | input | AW | Execute-stage source register 1 |
| ex_rs2 | input | AW | Execute-stage source register 2 |
| ex_rd | input | AW | Execute-stage destination |
| ex_wen | input | 1 | Execute-stage writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| ex_redirect | input | 1 | Taken branch or jump resolved in execute |
| mem_access | input | 1 | Memory-stage load or store uses the port |
| mem_rd | input | AW | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage writes a register |
| wb_rd | input | AW | Write-back-stage destination |
| wb_wen | input | 1 | Write-back-stage writes a register |
| grant_fetch | output | 1 | Port granted to instruction fetch |
| grant_data | output | 1 | Port granted to the data access |
| hold_pc | output | 1 | Keep the program counter |
| hold_ifid | output | 1 | Keep the IF/ID register |
| kill_ifid | output | 1 | Load a bubble into IF/ID |
| kill_idex | output | 1 | Load a bubble into ID/EX |
| fwd_a_sel | output | 2 | Operand A source: 0 register file, 1 MEM/WB, 2 EX/MEM |
| fwd_b_sel | output | 2 | Operand B source, same encoding |

## Verification
The assertions assume that inputs are clean two-state levels and settle within a cycle. They do not assume that the stage fields are mutually consistent: a redirect may coincide with a load-use pair or a port conflict, and the invariants still have to hold. The stimulus therefore draws every field independently. Register numbers come from a range of four, so matches, double matches and register 0 occur often. Directed cases pin down the combined conflict-plus-load-use cycle, a redirect over a stall, and the double-match priority.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_WB  = 2'd1,
    FWD_MEM = 2'd2
  } fwd_src_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          mem_wen,
  input  logic [AW-1:0] mem_rd,
  input  logic          wb_wen,
  input  logic [AW-1:0] wb_rd,
  output fwd_src_e      sel
);
  logic src_nz, hit_mem, hit_wb;

  assign src_nz  = |src;
  assign hit_mem = src_nz && mem_wen && (mem_rd == src);
  assign hit_wb  = src_nz && wb_wen && (wb_rd == src);

  // younger producer (EX/MEM) overrides older one
  always_comb begin
    sel = FWD_RF;
    if (hit_wb)  sel = FWD_WB;
    if (hit_mem) sel = FWD_MEM;
  end

  always_comb begin
    AST_ZERO_NEVER_BYPASSED: assert (src != '0 || sel == FWD_RF)
      else $error("register 0 bypassed"); // R6
    AST_OLDER_NOT_OVER_YOUNGER: assert (sel != FWD_WB || !(mem_wen && mem_rd == src))
      else $error("MEM/WB chosen over EX/MEM"); // R5
  end
endmodule

// File: rtl/hz_port_arb.sv
module hz_port_arb (
  input  logic fetch_req,
  input  logic mem_access,
  output logic grant_fetch,
  output logic grant_data,
  output logic conflict
);
  // the older instruction in MEM always owns the shared port
  assign grant_data  = mem_access;
  assign grant_fetch = fetch_req && !mem_access;
  assign conflict    = fetch_req && mem_access;

  always_comb begin
    AST_GRANT_EXCLUSIVE: assert ($onehot0({grant_fetch, grant_data}))
      else $error("port granted twice"); // R10
    AST_FETCH_LOSES: assert (!conflict || !grant_fetch)
      else $error("fetch won a conflict"); // R1
  end
endmodule

// File: rtl/hz_stall_ctl.sv
module hz_stall_ctl #(
  parameter int AW = 5
) (
  input  logic          conflict,
  input  logic          redirect,
  input  logic          ex_load,
  input  logic          ex_wen,
  input  logic [AW-1:0] ex_rd,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  output logic          hold_pc,
  output logic          hold_ifid,
  output logic          kill_ifid,
  output logic          kill_idex
);
  logic load_use;

  assign load_use = ex_load && ex_wen && (ex_rd != '0) &&
                    ((ex_rd == id_rs1) || (ex_rd == id_rs2));

  always_comb begin
    hold_pc   = 1'b0;
    hold_ifid = 1'b0;
    kill_ifid = 1'b0;
    kill_idex = 1'b0;
    if (redirect) begin
      // wrong-path slots in IF/ID and ID/EX are discarded
      kill_ifid = 1'b1;
      kill_idex = 1'b1;
    end else if (load_use) begin
      // covers the conflict case too: fetch result is irrelevant while held
      hold_pc   = 1'b1;
      hold_ifid = 1'b1;
      kill_idex = 1'b1;
    end else if (conflict) begin
      hold_pc   = 1'b1;
      kill_ifid = 1'b1;
    end
  end

  always_comb begin
    AST_FLUSH_BEATS_STALL: assert (!redirect || (!hold_pc && !hold_ifid))
      else $error("stall during redirect"); // R9
    AST_ONE_BUBBLE_ONLY: assert (!(hold_ifid && kill_ifid))
      else $error("IF/ID both held and killed"); // R8
    AST_ZERO_NO_STALL: assert (ex_rd != '0 || redirect || conflict || !hold_pc)
      else $error("stall on register 0"); // R6
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hz_pkg::*;
#(
  parameter int NREGS = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          fetch_req,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic          ex_redirect,
  input  logic          mem_access,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic          grant_fetch,
  output logic          grant_data,
  output logic          hold_pc,
  output logic          hold_ifid,
  output logic          kill_ifid,
  output logic          kill_idex,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel
);
  localparam int NOPS = 2;

  logic          conflict;
  logic [AW-1:0] op_src [NOPS];
  fwd_src_e      op_sel [NOPS];

  assign op_src[0] = ex_rs1;
  assign op_src[1] = ex_rs2;

  hz_port_arb u_arb (
    .fetch_req   (fetch_req),
    .mem_access  (mem_access),
    .grant_fetch (grant_fetch),
    .grant_data  (grant_data),
    .conflict    (conflict)
  );

  hz_stall_ctl #(.AW(AW)) u_stall (
    .conflict  (conflict),
    .redirect  (ex_redirect),
    .ex_load   (ex_load),
    .ex_wen    (ex_wen),
    .ex_rd     (ex_rd),
    .id_rs1    (id_rs1),
    .id_rs2    (id_rs2),
    .hold_pc   (hold_pc),
    .hold_ifid (hold_ifid),
    .kill_ifid (kill_ifid),
    .kill_idex (kill_idex)
  );

  for (genvar g = 0; g < NOPS; g++) begin : g_op
    hz_fwd_sel #(.AW(AW)) u_fwd (
      .src     (op_src[g]),
      .mem_wen (mem_wen),
      .mem_rd  (mem_rd),
      .wb_wen  (wb_wen),
      .wb_rd   (wb_rd),
      .sel     (op_sel[g])
    );
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  always_comb begin
    AST_LOADUSE_BUBBLES_EX: assert (ex_redirect || !hold_ifid || kill_idex)
      else $error("load-use hold without ID/EX bubble"); // R7
    AST_DATA_FOLLOWS_ACCESS: assert (grant_data == mem_access)
      else $error("data grant mismatch"); // R10
  end
endmodule

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREGS = 32;
  localparam int AW = $clog2(NREGS);

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          fetch_req, ex_wen, ex_load, ex_redirect, mem_access, mem_wen, wb_wen;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic          grant_fetch, grant_data, hold_pc, hold_ifid, kill_ifid, kill_idex;
  logic [1:0]    fwd_a_sel, fwd_b_sel;

  int total = 0;
  int bad = 0;

  pipe_hazard_ctrl #(.NREGS(NREGS)) u_pipe_hazard_ctrl (.*);

  function automatic logic [1:0] exp_fwd(input logic [AW-1:0] s);
    if (s == 0) return 2'd0;
    if (mem_wen && mem_rd == s) return 2'd2;
    if (wb_wen && wb_rd == s) return 2'd1;
    return 2'd0;
  endfunction

  function automatic string fwd_tag(input logic [AW-1:0] s);
    logic hm, hw;
    hm = mem_wen && mem_rd == s;
    hw = wb_wen && wb_rd == s;
    if (s == 0) return "R6";
    if (hm && hw) return "R5";
    if (hm) return "R3";
    return "R4";
  endfunction

  function automatic logic lu();
    return ex_load && ex_wen && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
  endfunction

  // {grant_fetch, grant_data, hold_pc, hold_ifid, kill_ifid, kill_idex}
  function automatic logic [5:0] exp_ctl();
    logic cf;
    logic [5:0] r;
    cf = fetch_req && mem_access;
    r = {fetch_req && !mem_access, mem_access, 4'b0000};
    if (ex_redirect)  r[3:0] = 4'b0011;
    else if (lu())    r[3:0] = 4'b1101;
    else if (cf)      r[3:0] = 4'b1010;
    return r;
  endfunction

  function automatic string ctl_tag();
    if (ex_redirect) return "R9";
    if (lu() && fetch_req && mem_access) return "R8";
    if (lu()) return "R7";
    if (ex_load && ex_wen && ex_rd == 0) return "R6";
    if (fetch_req && mem_access) return "R1";
    return "R2";
  endfunction

  task automatic check_all();
    logic [5:0] act, exp;
    #1;
    act = {grant_fetch, grant_data, hold_pc, hold_ifid, kill_ifid, kill_idex};
    exp = exp_ctl();
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s ctl act=%b exp=%b", ctl_tag(), act, exp);
    end
    total++;
    if (grant_fetch && grant_data) begin // R10
      bad++;
      $display("FAIL R10 grants act=%b%b exp=not both", grant_fetch, grant_data);
    end
    total++;
    if (fwd_a_sel !== exp_fwd(ex_rs1)) begin
      bad++;
      $display("FAIL %s fwd_a act=%0d exp=%0d", fwd_tag(ex_rs1), fwd_a_sel, exp_fwd(ex_rs1));
    end
    total++;
    if (fwd_b_sel !== exp_fwd(ex_rs2)) begin
      bad++;
      $display("FAIL %s fwd_b act=%0d exp=%0d", fwd_tag(ex_rs2), fwd_b_sel, exp_fwd(ex_rs2));
    end
  endtask

  task automatic idle();
    fetch_req = 1; ex_wen = 0; ex_load = 0; ex_redirect = 0; mem_access = 0;
    mem_wen = 0; wb_wen = 0; id_rs1 = 0; id_rs2 = 0; ex_rs1 = 0; ex_rs2 = 0;
    ex_rd = 0; mem_rd = 0; wb_rd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    @(negedge clk); check_all();                       // R2 reset-like idle state
    // R1 port conflict
    @(negedge clk); idle(); mem_access = 1; check_all();
    // R3 / R5 double match prefers EX/MEM
    @(negedge clk); idle(); ex_rs1 = 5; ex_rs2 = 6; mem_wen = 1; mem_rd = 5;
    wb_wen = 1; wb_rd = 5; check_all();
    // R4 MEM/WB only
    @(negedge clk); idle(); ex_rs2 = 9; wb_wen = 1; wb_rd = 9; check_all();
    // R6 register 0 writers
    @(negedge clk); idle(); mem_wen = 1; wb_wen = 1; ex_load = 1; ex_wen = 1;
    check_all();
    // R7 load-use on rs2
    @(negedge clk); idle(); ex_load = 1; ex_wen = 1; ex_rd = 7; id_rs2 = 7; check_all();
    // R8 load-use with port conflict
    @(negedge clk); mem_access = 1; check_all();
    // R9 redirect overrides the above
    @(negedge clk); ex_redirect = 1; check_all();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      fetch_req   = ($urandom % 4) != 0;
      ex_wen      = $urandom % 2;
      ex_load     = $urandom % 2;
      ex_redirect = ($urandom % 6) == 0;
      mem_access  = $urandom % 2;
      mem_wen     = $urandom % 2;
      wb_wen      = $urandom % 2;
      id_rs1 = AW'($urandom % 4); id_rs2 = AW'($urandom % 4);
      ex_rs1 = AW'($urandom % 4); ex_rs2 = AW'($urandom % 4);
      ex_rd  = AW'($urandom % 4); mem_rd = AW'($urandom % 4);
      wb_rd  = AW'($urandom % 4);
      check_all();
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule